// File: doc/BRIEF.md
# Narrow flow-control link transmitter

This block drives a 4-lane reverse-path link that carries only flow-control traffic. Words of 32 bits enter through a small queue. They may arrive padded inside a wider input word. Each word is cut into nibbles, most significant first, and sent one nibble per clock. Every frame opens with a header word. The header carries the control-ready and data-ready bits. When no complete frame is queued, the block sends idle frames so that those two bits keep reaching the far end. Every frame closes with a 16-bit vertical parity trailer. A sideband lane can carry an odd horizontal parity bit for every nibble.

An asynchronous backpressure input is brought into the clock domain and timed. If it stays asserted long enough while training is enabled, the block finishes the frame it is sending. It then emits a burst of alternating training words of programmable length before normal traffic resumes. The vertical parity is either a plain column XOR or a rotating DIP-16 sum, chosen by a configuration bit.

Top module: `fcl_nibble_tx`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, every link output is 0. `in_ready` is 1 from reset on.
- R2: A queued word is `in_word[IN_W-1 -: 32]` when `in_padded` is 1, and `in_word[31:0]` when it is 0. The remaining bits are discarded.
- R3: Every 32-bit word goes out on `lnk_nib` over 8 consecutive cycles, bits 31:28 first and bits 3:0 last.
- R4: A frame is a header word, then the payload words, then a trailer. The header has bit 31 = control-ready, bit 30 = data-ready, bits 29:28 = 01 for a flow frame or 00 for an idle frame, and bits 27:0 = 0. The trailer is the 16-bit vertical parity, sent as 4 nibbles with the most significant first. `lnk_start` is 1 only on the first nibble of a header.
- R5: The ready bits are sampled at the clock on which the header is loaded. A flow frame starts only when all of its words, up to the one marked `in_last`, are queued. Otherwise an idle frame (header and trailer only) is sent.
- R6: With `cfg_hpar_en` = 1, `lnk_hpar` makes the 5 bits {`lnk_nib`,`lnk_hpar`} odd parity. With it at 0, `lnk_hpar` is 0.
- R7: Standard vertical parity (`cfg_vpar_dip` = 0) is the XOR of all 16-bit halves of the header and payload words.
- R8: DIP-16 parity (`cfg_vpar_dip` = 1) starts at 0. For each 16-bit half, upper half first and in send order, the running value is rotated left by one bit and then XORed with the half.
- R9: Backpressure passes through two flops. With `cfg_train_en` = 1, a synchronised high level held for 32 consecutive clocks raises one training request. A shorter level raises none, and any low level restarts the count. With `cfg_train_en` = 0, no request is raised.
- R10: A pending request is served at the next frame boundary. The block sends `cfg_train_reps`+1 words of 0xA5A5A5A5 with `lnk_train` = 1, so the first nibble is A and the nibbles alternate. Then normal frames resume.
- R11: A request that arrives while a frame is in flight does not cut that frame short. Every payload word and the trailer are sent before the training burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hpar_en | input | 1 | Enable per-nibble horizontal parity |
| cfg_vpar_dip | input | 1 | 1 selects DIP-16 trailer, 0 selects column XOR |
| cfg_train_en | input | 1 | Allow backpressure to request training |
| cfg_train_reps | input | REP_W | Training words sent, minus one |
| rdy_ctl_in | input | 1 | Control-ready bit to report |
| rdy_dat_in | input | 1 | Data-ready bit to report |
| bp_async | input | 1 | Asynchronous backpressure |
| in_valid | input | 1 | Queue write strobe |
| in_ready | output | 1 | Queue can accept a word |
| in_word | input | IN_W | Input word, possibly padded |
| in_padded | input | 1 | Word sits in the upper 32 bits |
| in_last | input | 1 | Word ends its frame |
| lnk_nib | output | 4 | Link data nibble |
| lnk_hpar | output | 1 | Horizontal parity lane |
| lnk_start | output | 1 | First nibble of a header |
| lnk_train | output | 1 | Nibble belongs to a training burst |

## Verification
The assertions assume that the configuration inputs change only while reset is held. They also assume that `in_valid` is raised only while `in_ready` is high, so the queue never overflows and every frame counted as complete really is in the queue when the sequencer pops it. The stimulus changes configuration only inside reset pulses. It checks `in_ready` on every write. It offers a new frame only after the previous one has been committed, which keeps the queue far below its depth. Backpressure is driven on the falling edge, so both the model and the synchroniser see a clean level at every rising edge.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [1:0] {
    ST_HDR = 2'd0,
    ST_PAY = 2'd1,
    ST_TRL = 2'd2,
    ST_TRN = 2'd3
  } seq_st_e;

  // R10: alternating training word, first nibble A
  localparam logic [31:0] TRAIN_WORD = 32'hA5A5_A5A5;
  localparam logic [1:0]  HDR_FLOW   = 2'b01;
  localparam logic [1:0]  HDR_IDLE   = 2'b00;

  // R7 / R8: one 16-bit step of the vertical parity
  function automatic logic [15:0] vp_step(input logic [15:0] v,
                                          input logic [15:0] h,
                                          input logic        dip);
    return dip ? ({v[14:0], v[15]} ^ h) : (v ^ h);
  endfunction

  function automatic logic [15:0] vp_word(input logic [15:0] v,
                                          input logic [31:0] w,
                                          input logic        dip);
    return vp_step(vp_step(v, w[31:16], dip), w[15:0], dip);
  endfunction

endpackage

// File: rtl/fcl_word_fifo.sv
module fcl_word_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/fcl_bp_detect.sv
module fcl_bp_detect #(
  parameter int HOLD = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic bp_async,
  input  logic enable,
  output logic req
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic             sync1, sync2;
  logic [CNT_W-1:0] cnt;

  // R9: the request fires on the HOLD-th consecutive synchronised high clock
  assign req = sync2 && (cnt == CNT_W'(HOLD - 1)) && enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      cnt   <= '0;
    end else begin
      sync1 <= bp_async;
      sync2 <= sync1;
      if (!sync2)                        cnt <= '0;
      else if (cnt != CNT_W'(HOLD))      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fcl_frame_seq.sv
module fcl_frame_seq
  import fcl_pkg::*;
#(
  parameter int REP_W = 4,
  parameter int FW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_vpar_dip,
  input  logic [REP_W-1:0] cfg_train_reps,
  input  logic             rdy_ctl,
  input  logic             rdy_dat,
  input  logic             frame_done,
  input  logic [31:0]      fifo_word,
  input  logic             fifo_last,
  output logic             fifo_pop,
  input  logic             train_req,
  output logic             train_pend,
  output logic [3:0]       cur_nib,
  output logic             cur_start,
  output logic             cur_train
);
  seq_st_e          st;
  logic [2:0]       idx;
  logic [31:0]      word_q;
  logic [15:0]      vp;
  logic [REP_W-1:0] rep;
  logic             hdr_flow_q, last_q;
  logic [FW-1:0]    favail;

  logic        slot_end, boundary, trn_go, hdr_go, flow, commit;
  logic [31:0] hdr_word;

  assign slot_end = (st == ST_TRL) ? (idx == 3'd3) : (idx == 3'd7);
  assign boundary = slot_end &&
                    ((st == ST_TRL) || ((st == ST_TRN) && (rep == cfg_train_reps)));
  assign trn_go   = boundary && train_pend;            // R10
  assign hdr_go   = boundary && !train_pend;
  assign flow     = (favail != '0);                    // R5
  assign commit   = hdr_go && flow;
  assign hdr_word = {rdy_ctl, rdy_dat, flow ? HDR_FLOW : HDR_IDLE, 28'h0}; // R4
  assign fifo_pop = slot_end && (((st == ST_HDR) && hdr_flow_q) ||
                                 ((st == ST_PAY) && !last_q));

  // R3: most significant nibble first
  assign cur_nib   = word_q[{3'd7 - idx, 2'b00} +: 4];
  assign cur_start = (st == ST_HDR) && (idx == 3'd0);
  assign cur_train = (st == ST_TRN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_TRL;
      idx        <= 3'd3;
      word_q     <= '0;
      vp         <= '0;
      rep        <= '0;
      hdr_flow_q <= 1'b0;
      last_q     <= 1'b0;
      favail     <= '0;
      train_pend <= 1'b0;
    end else begin
      train_pend <= (train_pend && !trn_go) || train_req;
      case ({frame_done, commit})
        2'b10:   favail <= favail + 1'b1;
        2'b01:   favail <= favail - 1'b1;
        default: favail <= favail;
      endcase
      if (!slot_end) begin
        idx <= idx + 1'b1;
      end else begin
        idx <= 3'd0;
        if (fifo_pop) begin
          word_q <= fifo_word;
          last_q <= fifo_last;
          vp     <= vp_word(vp, fifo_word, cfg_vpar_dip);
          st     <= ST_PAY;
        end else if ((st == ST_HDR) || (st == ST_PAY)) begin
          word_q <= {vp, 16'h0};                        // R7 / R8 trailer
          st     <= ST_TRL;
        end else if ((st == ST_TRN) && !boundary) begin
          rep    <= rep + 1'b1;
        end else if (trn_go) begin
          word_q <= TRAIN_WORD;
          rep    <= '0;
          st     <= ST_TRN;
        end else begin
          word_q     <= hdr_word;
          vp         <= vp_word(16'h0, hdr_word, cfg_vpar_dip);
          hdr_flow_q <= flow;
          st         <= ST_HDR;
        end
      end
    end
  end
endmodule

// File: rtl/fcl_lane_out.sv
module fcl_lane_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       hpar_en,
  input  logic [3:0] cur_nib,
  input  logic       cur_start,
  input  logic       cur_train,
  output logic [3:0] lnk_nib,
  output logic       lnk_hpar,
  output logic       lnk_start,
  output logic       lnk_train
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lnk_nib   <= '0;
      lnk_hpar  <= 1'b0;
      lnk_start <= 1'b0;
      lnk_train <= 1'b0;
    end else begin
      lnk_nib   <= cur_nib;
      lnk_hpar  <= hpar_en ? ~^cur_nib : 1'b0;          // R6
      lnk_start <= cur_start;
      lnk_train <= cur_train;
    end
  end
endmodule

// File: rtl/fcl_nibble_tx.sv
module fcl_nibble_tx #(
  parameter int IN_W       = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int BP_HOLD    = 32,
  parameter int REP_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hpar_en,
  input  logic             cfg_vpar_dip,
  input  logic             cfg_train_en,
  input  logic [REP_W-1:0] cfg_train_reps,
  input  logic             rdy_ctl_in,
  input  logic             rdy_dat_in,
  input  logic             bp_async,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_word,
  input  logic             in_padded,
  input  logic             in_last,
  output logic [3:0]       lnk_nib,
  output logic             lnk_hpar,
  output logic             lnk_start,
  output logic             lnk_train
);
  localparam int FW = $clog2(FIFO_DEPTH) + 1;

  logic        fifo_full, fifo_empty, fifo_pop, push, train_req, train_pend;
  logic [31:0] stripped;
  logic [32:0] fifo_rd;
  logic [3:0]  cur_nib;
  logic        cur_start, cur_train;

  // R2: strip padding of wider words
  assign stripped = in_padded ? in_word[IN_W-1 -: 32] : in_word[31:0];
  assign in_ready = !fifo_full;
  assign push     = in_valid && !fifo_full;

  fcl_word_fifo #(.W(33), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .wdata ({in_last, stripped}),
    .full  (fifo_full),
    .pop   (fifo_pop),
    .rdata (fifo_rd),
    .empty (fifo_empty)
  );

  fcl_bp_detect #(.HOLD(BP_HOLD)) bp_i (
    .clk      (clk),
    .rst      (rst),
    .bp_async (bp_async),
    .enable   (cfg_train_en),
    .req      (train_req)
  );

  fcl_frame_seq #(.REP_W(REP_W), .FW(FW)) seq_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_vpar_dip   (cfg_vpar_dip),
    .cfg_train_reps (cfg_train_reps),
    .rdy_ctl        (rdy_ctl_in),
    .rdy_dat        (rdy_dat_in),
    .frame_done     (push && in_last),
    .fifo_word      (fifo_rd[31:0]),
    .fifo_last      (fifo_rd[32]),
    .fifo_pop       (fifo_pop),
    .train_req      (train_req),
    .train_pend     (train_pend),
    .cur_nib        (cur_nib),
    .cur_start      (cur_start),
    .cur_train      (cur_train)
  );

  fcl_lane_out out_i (
    .clk       (clk),
    .rst       (rst),
    .hpar_en   (cfg_hpar_en),
    .cur_nib   (cur_nib),
    .cur_start (cur_start),
    .cur_train (cur_train),
    .lnk_nib   (lnk_nib),
    .lnk_hpar  (lnk_hpar),
    .lnk_start (lnk_start),
    .lnk_train (lnk_train)
  );
endmodule

// File: rtl/fcl_nibble_tx_chk.sv
module fcl_nibble_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_hpar_en,
  input logic       cfg_train_en,
  input logic [3:0] lnk_nib,
  input logic       lnk_hpar,
  input logic       lnk_start,
  input logic       lnk_train,
  input logic       fifo_pop,
  input logic       fifo_empty,
  input logic       train_pend
);
  a_r6_hpar_odd: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cfg_hpar_en)) |-> ((^{lnk_nib, lnk_hpar}) == 1'b1));

  a_r6_hpar_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cfg_hpar_en)) |-> !lnk_hpar);

  a_r10_train_first_a: assert property (@(posedge clk) disable iff (rst)
    $rose(lnk_train) |-> (lnk_nib == 4'hA));

  a_r10_train_alternates: assert property (@(posedge clk) disable iff (rst)
    (lnk_train && $past(lnk_train)) |-> (lnk_nib == ~$past(lnk_nib)));

  a_r4_start_not_train: assert property (@(posedge clk) disable iff (rst)
    lnk_start |-> !lnk_train);

  a_r4_start_single: assert property (@(posedge clk) disable iff (rst)
    lnk_start |=> !lnk_start);

  a_r5_no_underrun: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  a_r9_train_gated: assert property (@(posedge clk) disable iff (rst)
    $rose(train_pend) |-> $past(cfg_train_en));
endmodule

bind fcl_nibble_tx fcl_nibble_tx_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_hpar_en  (cfg_hpar_en),
  .cfg_train_en (cfg_train_en),
  .lnk_nib      (lnk_nib),
  .lnk_hpar     (lnk_hpar),
  .lnk_start    (lnk_start),
  .lnk_train    (lnk_train),
  .fifo_pop     (fifo_pop),
  .fifo_empty   (fifo_empty),
  .train_pend   (train_pend)
);

// File: tb/fcl_nibble_tx_tb_top.sv
module fcl_nibble_tx_tb_top;
  localparam int IN_W  = 64;
  localparam int REP_W = 4;
  localparam int HOLD  = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_hpar_en = 1'b0, cfg_vpar_dip = 1'b0, cfg_train_en = 1'b0;
  logic [REP_W-1:0] cfg_train_reps = '0;
  logic             rdy_ctl_in = 1'b0, rdy_dat_in = 1'b0, bp_async = 1'b0;
  logic             in_valid = 1'b0, in_padded = 1'b0, in_last = 1'b0;
  logic [IN_W-1:0]  in_word = '0;
  logic             in_ready;
  logic [3:0]       lnk_nib;
  logic             lnk_hpar, lnk_start, lnk_train;

  always #2 clk = ~clk;

  fcl_nibble_tx #(.IN_W(IN_W), .FIFO_DEPTH(16), .BP_HOLD(HOLD), .REP_W(REP_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_hpar_en(cfg_hpar_en), .cfg_vpar_dip(cfg_vpar_dip),
    .cfg_train_en(cfg_train_en), .cfg_train_reps(cfg_train_reps),
    .rdy_ctl_in(rdy_ctl_in), .rdy_dat_in(rdy_dat_in), .bp_async(bp_async),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .in_padded(in_padded), .in_last(in_last), .lnk_nib(lnk_nib),
    .lnk_hpar(lnk_hpar), .lnk_start(lnk_start), .lnk_train(lnk_train)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [3:0]  nq[$];
  bit          sq[$], tq[$];
  string       gq[$];
  logic [32:0] wq[$];
  bit          wpad[$];
  int          favail = 0, cnt = 0;
  bit          s1 = 0, s2 = 0, pend = 0, live = 0;
  logic [3:0]  e_nib = '0;
  logic        e_hpar = 0, e_start = 0, e_train = 0;
  string       e_tag = "R1";
  int          obs_train = 0, obs_start = 0;

  function automatic logic [15:0] vs(input logic [15:0] v, input logic [15:0] h, input bit dip);
    return dip ? ({v[14:0], v[15]} ^ h) : (v ^ h);
  endfunction

  function automatic logic [15:0] vw(input logic [15:0] v, input logic [31:0] w, input bit dip);
    return vs(vs(v, w[31:16], dip), w[15:0], dip);
  endfunction

  task automatic put_word(input logic [31:0] w, input bit st, input bit tr, input string tag);
    for (int i = 0; i < 8; i++) begin
      nq.push_back(w[31-4*i -: 4]);
      sq.push_back(st && (i == 0));
      tq.push_back(tr);
      gq.push_back(tag);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      nq.delete(); sq.delete(); tq.delete(); gq.delete(); wq.delete(); wpad.delete();
      nq.push_back(4'h0); sq.push_back(0); tq.push_back(0); gq.push_back("R1");
      e_nib = '0; e_hpar = 0; e_start = 0; e_train = 0; e_tag = "R1";
      favail = 0; cnt = 0; s1 = 0; s2 = 0; pend = 0; live = 1;
    end else begin
      bit start_trn, req;
      e_nib   = nq.pop_front();
      e_start = sq.pop_front();
      e_train = tq.pop_front();
      e_tag   = gq.pop_front();
      e_hpar  = cfg_hpar_en ? ~^e_nib : 1'b0;
      start_trn = 0;
      if (nq.size() == 0) begin
        if (pend) begin
          for (int r = 0; r <= int'(cfg_train_reps); r++) put_word(32'hA5A5A5A5, 0, 1, "R10");
          start_trn = 1;
        end else begin
          logic [31:0] hdr;
          logic [15:0] v;
          bit flow;
          flow = (favail > 0);
          hdr  = {rdy_ctl_in, rdy_dat_in, flow ? 2'b01 : 2'b00, 28'h0};
          put_word(hdr, 1, 0, flow ? "R4" : "R5");
          v = vw(16'h0, hdr, cfg_vpar_dip);
          if (flow) begin
            logic [32:0] w;
            bit p;
            favail--;
            do begin
              w = wq.pop_front();
              p = wpad.pop_front();
              put_word(w[31:0], 0, 0, p ? "R2" : "R3");
              v = vw(v, w[31:0], cfg_vpar_dip);
            end while (!w[32]);
          end
          for (int i = 0; i < 4; i++) begin
            nq.push_back(v[15-4*i -: 4]); sq.push_back(0); tq.push_back(0);
            gq.push_back(cfg_vpar_dip ? "R8" : "R7");
          end
        end
      end
      req  = s2 && (cnt == HOLD - 1) && cfg_train_en;
      cnt  = s2 ? ((cnt == HOLD) ? HOLD : cnt + 1) : 0;
      s2   = s1;
      s1   = bp_async;
      pend = (pend && !start_trn) || req;
      if (in_valid) begin
        wq.push_back({in_last, in_padded ? in_word[IN_W-1 -: 32] : in_word[31:0]});
        wpad.push_back(in_padded);
        if (in_last) favail++;
      end
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      checks++;
      if (lnk_nib !== e_nib || lnk_start !== e_start || lnk_train !== e_train) begin
        errors++;
        $display("FAIL %s actual nib=%h start=%b train=%b expected nib=%h start=%b train=%b",
                 e_tag, lnk_nib, lnk_start, lnk_train, e_nib, e_start, e_train);
      end
      checks++;
      if (lnk_hpar !== e_hpar) begin
        errors++;
        $display("FAIL R6 actual hpar=%b expected hpar=%b", lnk_hpar, e_hpar);
      end
      if (lnk_train === 1'b1) obs_train++;
      if (lnk_start === 1'b1) obs_start++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit hp, input bit dip, input bit ten, input int reps);
    @(negedge clk);
    rst = 1'b1;
    cfg_hpar_en = hp; cfg_vpar_dip = dip; cfg_train_en = ten;
    cfg_train_reps = REP_W'(reps);
    repeat (3) @(negedge clk);
    chk(lnk_nib == 4'h0 && !lnk_start && !lnk_train && !lnk_hpar, "R1", int'(lnk_nib), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    rst = 1'b0;
  endtask

  task automatic send_frame(input int n);
    while (favail != 0) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      in_valid   = 1'b1;
      in_word    = {$urandom, $urandom};
      in_padded  = $urandom % 2;
      in_last    = (i == n - 1);
      rdy_ctl_in = $urandom % 2;
      rdy_dat_in = $urandom % 2;
      chk(in_ready == 1'b1, "R2", int'(in_ready), 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic hold_bp(input int n);
    bp_async = 1'b1;
    repeat (n) @(negedge clk);
    bp_async = 1'b0;
  endtask

  initial begin
    int base;
    // phase 1: odd hparity, column XOR trailer, training enabled (2 words)
    do_reset(1, 0, 1, 1);
    base = obs_start;
    repeat (40) @(negedge clk);
    chk(obs_start - base >= 2, "R5", obs_start - base, 2);   // idle headers keep flowing
    send_frame(1); send_frame(3); send_frame(5); send_frame(2);
    repeat (80) @(negedge clk);
    base = obs_train;
    hold_bp(31);                                              // R9: one short of the limit
    repeat (150) @(negedge clk);
    chk(obs_train == base, "R9", obs_train - base, 0);
    base = obs_train;
    hold_bp(32);                                              // R9: exactly the limit
    repeat (150) @(negedge clk);
    chk(obs_train - base == 16, "R10", obs_train - base, 16);

    // phase 2: no hparity, DIP-16 trailer, training disabled
    do_reset(0, 1, 0, 2);
    send_frame(4); send_frame(1); send_frame(2);
    base = obs_train;
    hold_bp(60);
    repeat (150) @(negedge clk);
    chk(obs_train == base, "R9", obs_train - base, 0);

    // phase 3: R11 request lands while frames are in flight
    do_reset(1, 1, 1, 3);
    base = obs_train;
    fork
      begin send_frame(5); send_frame(4); send_frame(5); end
      begin repeat (20) @(negedge clk); hold_bp(40); end
    join
    repeat (300) @(negedge clk);
    chk(obs_train - base == 32, "R11", obs_train - base, 32);
    send_frame(3);
    repeat (60) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule